// File: doc/BRIEF.md
# USART Register Access Sequencer

This block sits behind the CPU write port of a serial interface and decides which internal register each write lands in. A data write (command/data select low) is simple: once setup is done it goes to the transmit holding byte. A control write (select high) has no fixed target. Its destination depends on how far the setup has progressed since the last reset. The first control write is the mode byte. In synchronous mode, one or two sync characters follow it. After that, control writes are command bytes.

The history is held in a four-state machine, exposed on `phase`:

| State | Code | What a control write does here |
|---|---|---|
| `PH_MODE` | 0 | Loads the mode byte. Goes to `PH_SYNC_A` if mode bits 1:0 are 00, otherwise to `PH_RUN`. |
| `PH_SYNC_A` | 1 | Loads the first sync character. Goes to `PH_RUN` if mode bit 7 is 1, otherwise to `PH_SYNC_B`. |
| `PH_SYNC_B` | 2 | Loads the second sync character, then goes to `PH_RUN`. |
| `PH_RUN` | 3 | Loads the command byte. If bit 6 of the byte is set, it returns to `PH_MODE` instead and leaves the command register unchanged. |

A write is taken on the clock edge where the write strobe is first seen high while chip select is high. Holding the strobe high causes no further writes.

Top module: `usart_wr_seq`

## Requirements
- R1: After `rst`, `phase` is 0 (`PH_MODE`), every register output is 0 and `dout_load` is low.
- R2: A write is accepted only on the first clock where `wr_stb` is high after being low. Holding `wr_stb` high for several cycles produces exactly one register update and one `dout_load` pulse. A data byte that changes while the strobe stays high is not taken.
- R3: In `PH_MODE`, a control write loads `mode_q` with the written byte.
- R4: A mode byte whose bits 1:0 are not 00 moves `phase` straight to 3 (`PH_RUN`).
- R5: A mode byte with bits 1:0 = 00 and bit 7 = 0 moves `phase` to 1. The next control write loads `sync_a_q` and sets `phase` to 2. The one after that loads `sync_b_q` and sets `phase` to 3.
- R6: A mode byte with bits 1:0 = 00 and bit 7 = 1 moves `phase` to 1. The next control write loads `sync_a_q` and sets `phase` to 3, and `sync_b_q` is left unchanged.
- R7: In `PH_RUN`, a control write with bit 6 = 0 loads `cmd_q`.
- R8: In `PH_RUN`, a control write with bit 6 = 1 sets `phase` to 0 and leaves `cmd_q` unchanged.
- R9: In `PH_RUN`, a data write loads `dout_q` and raises `dout_load` for exactly one cycle, in the cycle after the accepting edge.
- R10: A data write while `phase` is not 3 changes neither `dout_q` nor `phase`, and raises no `dout_load`.
- R11: A strobe while `chip_sel` is low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| chip_sel | input | 1 | Chip select, active high |
| wr_stb | input | 1 | Write strobe, level; its rising edge marks a write |
| cd_sel | input | 1 | 1 = control write, 0 = data write |
| wdata | input | 8 | Write data bus |
| mode_q | output | 8 | Latched mode byte |
| sync_a_q | output | 8 | First sync character |
| sync_b_q | output | 8 | Second sync character |
| cmd_q | output | 8 | Current operating command |
| dout_q | output | 8 | Transmit holding byte |
| dout_load | output | 1 | One-cycle pulse after each accepted data load |
| phase | output | 2 | Access phase: 0 mode, 1 first sync, 2 second sync, 3 running |

## Verification
Two situations are hard to reach from the ports. The first is a second pass through the sync phase with a one-character mode after an earlier two-character setup. This is the only way to show that `sync_b_q` is left alone. The bench reaches it by completing a two-sync setup, issuing a reset command, and then writing a mode byte with bit 7 set. The second is a data write made while still in the sync phase, which must be dropped. The bench places such a write between the mode byte and the first sync byte.

// File: rtl/usart_seq_pkg.sv
package usart_seq_pkg;

    // Access phase of the sequencer; the encoding is visible on the phase port.
    typedef enum logic [1:0] {
        PH_MODE   = 2'd0,
        PH_SYNC_A = 2'd1,
        PH_SYNC_B = 2'd2,
        PH_RUN    = 2'd3
    } seq_phase_e;

    // Field positions the sequencer decodes.
    localparam int unsigned FACTOR_LSB      = 0;
    localparam int unsigned FACTOR_MSB      = 1;
    localparam int unsigned SINGLE_SYNC_BIT = 7;
    localparam int unsigned SOFT_RST_BIT    = 6;

    // Index of each control register in the register bank.
    localparam int unsigned CREG_MODE   = 0;
    localparam int unsigned CREG_SYNC_A = 1;
    localparam int unsigned CREG_SYNC_B = 2;
    localparam int unsigned CREG_CMD    = 3;
    localparam int unsigned CREG_NUM    = 4;

endpackage

// File: rtl/usart_wr_edge.sv
module usart_wr_edge (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic wr_stb,
    input  logic cd_sel,
    output logic ctl_acc,
    output logic dat_acc
);
    logic stb_d;
    logic stb_rise;

    always_ff @(posedge clk) begin
        if (rst) stb_d <= 1'b0;
        else     stb_d <= wr_stb;
    end

    assign stb_rise = wr_stb & ~stb_d;
    assign ctl_acc  = stb_rise & chip_sel & cd_sel;
    assign dat_acc  = stb_rise & chip_sel & ~cd_sel;

    // R2
    no_double_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_acc || dat_acc) |=> !(ctl_acc || dat_acc));

endmodule

// File: rtl/usart_seq_fsm.sv
module usart_seq_fsm
    import usart_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_acc,
    input  logic              dat_acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mode_single,
    output seq_phase_e        state,
    output logic [CREG_NUM-1:0] creg_ld,
    output logic              dout_ld
);
    seq_phase_e nxt;
    logic       lsb_sync;
    logic       soft_rst;

    assign lsb_sync = (wdata[FACTOR_MSB:FACTOR_LSB] == 2'b00);
    assign soft_rst = wdata[SOFT_RST_BIT];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= PH_MODE;
        else     state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            PH_MODE:   if (ctl_acc) nxt = lsb_sync ? PH_SYNC_A : PH_RUN;
            PH_SYNC_A: if (ctl_acc) nxt = mode_single ? PH_RUN : PH_SYNC_B;
            PH_SYNC_B: if (ctl_acc) nxt = PH_RUN;
            PH_RUN:    if (ctl_acc && soft_rst) nxt = PH_MODE;
            default:   nxt = PH_MODE;
        endcase
    end

    // Load enables
    always_comb begin
        creg_ld = '0;
        dout_ld = 1'b0;
        unique case (state)
            PH_MODE:   creg_ld[CREG_MODE]   = ctl_acc;
            PH_SYNC_A: creg_ld[CREG_SYNC_A] = ctl_acc;
            PH_SYNC_B: creg_ld[CREG_SYNC_B] = ctl_acc;
            PH_RUN: begin
                creg_ld[CREG_CMD] = ctl_acc & ~soft_rst;
                dout_ld           = dat_acc;
            end
            default: ;
        endcase
    end

    // R4
    async_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_MODE && ctl_acc && wdata[FACTOR_MSB:FACTOR_LSB] != 2'b00)
        |=> state == PH_RUN);

    // R5
    two_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SYNC_A && ctl_acc && !mode_single) |=> state == PH_SYNC_B);

    // R6
    one_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SYNC_A && ctl_acc && mode_single) |=> state == PH_RUN);

    // R8
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_RUN && ctl_acc && wdata[SOFT_RST_BIT]) |=> state == PH_MODE);

    // R10
    data_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != PH_RUN && dat_acc && !ctl_acc) |=> $stable(state));

endmodule

// File: rtl/usart_seq_regs.sv
module usart_seq_regs
    import usart_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CREG_NUM-1:0] creg_ld,
    input  logic                dout_ld,
    input  logic                dat_acc,
    input  seq_phase_e          phase,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   mode_q,
    output logic [DATA_W-1:0]   sync_a_q,
    output logic [DATA_W-1:0]   sync_b_q,
    output logic [DATA_W-1:0]   cmd_q,
    output logic [DATA_W-1:0]   dout_q,
    output logic                dout_load
);
    logic [DATA_W-1:0] bank [CREG_NUM];

    for (genvar g = 0; g < CREG_NUM; g++) begin : g_creg
        always_ff @(posedge clk) begin
            if (rst)             bank[g] <= '0;
            else if (creg_ld[g]) bank[g] <= wdata;
        end
    end

    assign mode_q   = bank[CREG_MODE];
    assign sync_a_q = bank[CREG_SYNC_A];
    assign sync_b_q = bank[CREG_SYNC_B];
    assign cmd_q    = bank[CREG_CMD];

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q    <= '0;
            dout_load <= 1'b0;
        end else begin
            dout_load <= dout_ld;
            if (dout_ld) dout_q <= wdata;
        end
    end

    // R3
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MODE && creg_ld[CREG_MODE]) |=> mode_q == $past(wdata));

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_RUN) |=> $stable(cmd_q));

    // R9
    dout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dout_load |=> !dout_load);

    // R10
    early_data_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_acc && phase != PH_RUN) |=> (!dout_load && $stable(dout_q)));

endmodule

// File: rtl/usart_wr_seq.sv
module usart_wr_seq
    import usart_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel,
    input  logic              wr_stb,
    input  logic              cd_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] sync_a_q,
    output logic [DATA_W-1:0] sync_b_q,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] dout_q,
    output logic              dout_load,
    output logic [1:0]        phase
);
    logic                ctl_acc;
    logic                dat_acc;
    seq_phase_e          state;
    logic [CREG_NUM-1:0] creg_ld;
    logic                dout_ld;

    usart_wr_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .chip_sel (chip_sel),
        .wr_stb   (wr_stb),
        .cd_sel   (cd_sel),
        .ctl_acc  (ctl_acc),
        .dat_acc  (dat_acc)
    );

    usart_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctl_acc     (ctl_acc),
        .dat_acc     (dat_acc),
        .wdata       (wdata),
        .mode_single (mode_q[SINGLE_SYNC_BIT]),
        .state       (state),
        .creg_ld     (creg_ld),
        .dout_ld     (dout_ld)
    );

    usart_seq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .creg_ld   (creg_ld),
        .dout_ld   (dout_ld),
        .dat_acc   (dat_acc),
        .phase     (state),
        .wdata     (wdata),
        .mode_q    (mode_q),
        .sync_a_q  (sync_a_q),
        .sync_b_q  (sync_b_q),
        .cmd_q     (cmd_q),
        .dout_q    (dout_q),
        .dout_load (dout_load)
    );

    assign phase = state;

    // R11
    no_select_chk: assert property (@(posedge clk) disable iff (rst)
        (!chip_sel) |=> ($stable(phase) && $stable(cmd_q) && !dout_load));

endmodule

// File: tb/usart_wr_seq_tb_top.sv
module usart_wr_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_sel = 1'b0;
    logic       wr_stb = 1'b0;
    logic       cd_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] mode_q, sync_a_q, sync_b_q, cmd_q, dout_q;
    logic       dout_load;
    logic [1:0] phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usart_wr_seq dut_i (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .wr_stb(wr_stb),
        .cd_sel(cd_sel), .wdata(wdata), .mode_q(mode_q), .sync_a_q(sync_a_q),
        .sync_b_q(sync_b_q), .cmd_q(cmd_q), .dout_q(dout_q),
        .dout_load(dout_load), .phase(phase)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One strobe; returns dout_load seen in the cycle after the accepting edge.
    task automatic bus_wr(input logic cs, input logic cd, input logic [7:0] d,
                          output logic pulse);
        @(negedge clk);
        chip_sel = cs; cd_sel = cd; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        pulse = dout_load;
        wr_stb = 1'b0; chip_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 phase", {6'd0, phase}, 8'd0);
        chk("R1 mode", mode_q, 8'h00);
        chk("R1 cmd", cmd_q, 8'h00);
        chk("R1 dout", dout_q, 8'h00);
        chk("R1 sync", sync_a_q | sync_b_q, 8'h00);
        chk("R1 load", {7'd0, dout_load}, 8'd0);
    endtask

    task automatic t_async();
        logic p;
        bus_wr(1'b1, 1'b1, 8'h4E, p);
        chk("R3 mode", mode_q, 8'h4E);
        chk("R4 phase", {6'd0, phase}, 8'd3);
        bus_wr(1'b1, 1'b1, 8'h27, p);
        chk("R7 cmd", cmd_q, 8'h27);
        bus_wr(1'b1, 1'b0, 8'hA5, p);
        chk("R9 pulse", {7'd0, p}, 8'd1);
        chk("R9 dout", dout_q, 8'hA5);
        chk("R9 pulse end", {7'd0, dout_load}, 8'd0);
    endtask

    task automatic t_cmd_reset(input logic [7:0] keep_cmd);
        logic p;
        bus_wr(1'b1, 1'b1, 8'h40, p);
        chk("R8 phase", {6'd0, phase}, 8'd0);
        chk("R8 cmd kept", cmd_q, keep_cmd);
    endtask

    task automatic t_ignored_data();
        logic p;
        bus_wr(1'b1, 1'b0, 8'h3C, p);
        chk("R10 pulse", {7'd0, p}, 8'd0);
        chk("R10 dout", dout_q, 8'hA5);
        chk("R10 phase", {6'd0, phase}, 8'd0);
    endtask

    task automatic t_sync_two();
        logic p;
        bus_wr(1'b1, 1'b1, 8'h1C, p);
        chk("R5 mode", mode_q, 8'h1C);
        chk("R5 phase1", {6'd0, phase}, 8'd1);
        bus_wr(1'b1, 1'b0, 8'h11, p);
        chk("R10 sync pulse", {7'd0, p}, 8'd0);
        chk("R10 sync phase", {6'd0, phase}, 8'd1);
        bus_wr(1'b1, 1'b1, 8'h16, p);
        chk("R5 sync_a", sync_a_q, 8'h16);
        chk("R5 phase2", {6'd0, phase}, 8'd2);
        bus_wr(1'b1, 1'b1, 8'h96, p);
        chk("R5 sync_b", sync_b_q, 8'h96);
        chk("R5 phase3", {6'd0, phase}, 8'd3);
        bus_wr(1'b1, 1'b1, 8'h15, p);
        chk("R7 cmd sync", cmd_q, 8'h15);
    endtask

    task automatic t_sync_one();
        logic p;
        bus_wr(1'b1, 1'b1, 8'h9C, p);
        chk("R6 phase1", {6'd0, phase}, 8'd1);
        bus_wr(1'b1, 1'b1, 8'hAA, p);
        chk("R6 sync_a", sync_a_q, 8'hAA);
        chk("R6 phase3", {6'd0, phase}, 8'd3);
        chk("R6 sync_b kept", sync_b_q, 8'h96);
        bus_wr(1'b1, 1'b1, 8'h05, p);
        chk("R7 cmd one", cmd_q, 8'h05);
    endtask

    task automatic t_strobe_hold();
        int pulses = 0;
        @(negedge clk);
        chip_sel = 1'b1; cd_sel = 1'b0; wdata = 8'h5A; wr_stb = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (dout_load) pulses++;
            wdata = 8'h77;
        end
        wr_stb = 1'b0; chip_sel = 1'b0;
        @(negedge clk);
        if (dout_load) pulses++;
        chk("R2 pulses", pulses[7:0], 8'd1);
        chk("R2 dout", dout_q, 8'h5A);
    endtask

    task automatic t_cs_low();
        logic p;
        bus_wr(1'b0, 1'b0, 8'hEE, p);
        chk("R11 pulse", {7'd0, p}, 8'd0);
        chk("R11 dout", dout_q, 8'h5A);
        bus_wr(1'b0, 1'b1, 8'h40, p);
        chk("R11 phase", {6'd0, phase}, 8'd3);
        chk("R11 cmd", cmd_q, 8'h05);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reset();
        t_async();
        t_cmd_reset(8'h27);
        t_ignored_data();
        t_sync_two();
        t_cmd_reset(8'h15);
        t_sync_one();
        t_strobe_hold();
        t_cs_low();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule